// File: doc/BRIEF.md
# One-Shot Match Countdown Timer

This block is a 32-bit system timer that software reaches through a plain word-wide register bus. Writing a target value to the match register starts a countdown. The length of the countdown is the distance from the stored counter value to the target, and the distance wraps through zero when the target is not above the stored value. A tick-enable input advances the countdown by one step. This lets a fast system clock model a slower timebase, for example a nominal 50 MHz tick.

The readable counter is the match value minus the remaining count, so software sees a value that climbs toward the target. When the countdown runs out, the stored counter takes the match value, a sticky status flag is set and the countdown stops. The timer stays stopped until software writes the match register again. The interrupt output is a level signal equal to the status flag gated by an enable bit. Software clears the flag by writing the status register.

The register bus is control traffic, so it uses a plain strobe rather than a stream handshake. A write takes effect at the clock edge on which `bus_en` and `bus_we` are both high, and it can never stall. Read data is a side-effect-free decode of `bus_addr` that is valid in the same cycle.

Top module: `match_timer`

## Requirements
- R1: After reset, the counter reads 0, status reads 0, interrupt enable reads 0 and `irq_o` is low. The countdown is stopped, so ticks change nothing until the match register is written.
- R2: A write of value m to byte offset 0x00 loads a countdown of length L. With c as the stored counter value (0 after reset, and afterwards the match value of the last expiry), L = m - c when m > c, and L = m + (all-ones - c) modulo 2^W otherwise. A length of 0 expires on the first tick.
- R3: A read at offset 0x10 returns the match value minus the remaining count. Each cycle with `tick_en` high while running raises the read value by one.
- R4: While `tick_en` is low, the countdown, the counter read and the flag do not change.
- R5: On the tick that ends the countdown, the status flag is set and the counter reads the match value from then on. Later ticks change nothing until the next match write.
- R6: Status is bit 0 at offset 0x14 and interrupt enable is bit 0 at offset 0x1C, both with all other bits reading 0. The match register is write-only and reads 0, and every other offset reads 0.
- R7: `irq_o` is high exactly when the status flag and the enable bit are both 1, including when the enable bit is set after the flag.
- R8: Any write to offset 0x14 clears the flag and drops `irq_o`. If the countdown expires in the same cycle, the flag stays set.
- R9: Writes to any offset other than 0x00, 0x14 and 0x1C, misaligned byte offsets included, change no state.
- R10: A match write in a cycle with `tick_en` high loads the countdown and that tick is not applied. A match write while running measures from the stored counter value, not from the value currently read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances the countdown by one when high |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high with `bus_en` |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data decoded from `bus_addr` |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded properties take for granted that `bus_addr`, `bus_en` and `bus_we` are known at every clock edge, and that `tick_en` is a clean level that is sampled only at the edge. Stimulus changes all inputs on the falling edge and parks the bus idle on the counter offset between accesses, so reads never disturb state. A six-bit instance is swept over pairs of stored counter and new match values that include equal values, zero, the all-ones value and the wrap case that yields a zero length. The expected counter value after every tick and the exact expiry cycle are computed arithmetically.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_MATCH  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STATUS,
    SEL_IEN
  } reg_sel_e;
endpackage

// File: rtl/match_timer_decode.sv
module match_timer_decode
  import match_timer_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              wr_match,
  output logic              wr_status,
  output logic              wr_ien
);
  always_comb begin
    case (addr)
      OFS_MATCH:  sel = SEL_MATCH;
      OFS_COUNT:  sel = SEL_COUNT;
      OFS_STATUS: sel = SEL_STATUS;
      OFS_IEN:    sel = SEL_IEN;
      default:    sel = SEL_NONE;
    endcase
  end

  // only defined writable offsets produce strobes; all others fall away
  assign wr_match  = en && we && (sel == SEL_MATCH);
  assign wr_status = en && we && (sel == SEL_STATUS);
  assign wr_ien    = en && we && (sel == SEL_IEN);
endmodule

// File: rtl/match_timer_countdown.sv
module match_timer_countdown #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_view,
  output logic         expire
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] match_q, base_q, remain_q, load_len;
  logic         run_q;

  // distance from the stored counter to the new target, wrapping through zero
  assign load_len = (load_val > base_q) ? (load_val - base_q)
                                        : (load_val + (ONES - base_q));

  assign expire     = run_q && tick_en && !load && (remain_q <= W'(1));
  assign count_view = match_q - remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      base_q   <= '0;
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (load) begin
      match_q  <= load_val;
      remain_q <= load_len;
      run_q    <= 1'b1;
    end else if (expire) begin
      base_q   <= match_q;
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (run_q && tick_en) begin
      remain_q <= remain_q - W'(1);
    end
  end

  // R2
  load_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> run_q);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !load && remain_q > W'(1)) |=> (remain_q == $past(remain_q) - W'(1)));

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> ($stable(remain_q) && $stable(run_q) && $stable(match_q)));

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load) |=> (!run_q && $stable(count_view)));
endmodule

// File: rtl/match_timer_irq.sv
module match_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ien_we,
  input  logic ien_d,
  output logic flag,
  output logic ien,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ien  <= 1'b0;
    end else begin
      if (set)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (ien_we)   ien  <= ien_d;
    end
  end

  assign irq = flag && ien;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_o
);
  reg_sel_e     sel;
  logic         wr_match, wr_status, wr_ien;
  logic [W-1:0] count_view;
  logic         expire, flag, ien;

  match_timer_decode u_dec (
    .addr      (bus_addr),
    .en        (bus_en),
    .we        (bus_we),
    .sel       (sel),
    .wr_match  (wr_match),
    .wr_status (wr_status),
    .wr_ien    (wr_ien)
  );

  match_timer_countdown #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .load       (wr_match),
    .load_val   (bus_wdata),
    .count_view (count_view),
    .expire     (expire)
  );

  match_timer_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (expire),
    .clr    (wr_status),
    .ien_we (wr_ien),
    .ien_d  (bus_wdata[0]),
    .flag   (flag),
    .ien    (ien),
    .irq    (irq_o)
  );

  always_comb begin
    case (sel)
      SEL_COUNT:  bus_rdata = count_view;
      SEL_STATUS: bus_rdata = {{(W-1){1'b0}}, flag};
      SEL_IEN:    bus_rdata = {{(W-1){1'b0}}, ien};
      default:    bus_rdata = '0;
    endcase
  end

  // R5
  expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  // R8
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !expire) |=> !irq_o);
endmodule

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
  localparam int BW = 6;
  localparam int MX = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = 8'h10;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          irq_o;

  int nchk = 0;
  int nfail = 0;
  int cur_c = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  match_timer #(.W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    nchk++;
    if (act !== exp_v) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = BW'(d);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 8'h10;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
    bus_addr = 8'h10;
  endtask

  function automatic int len_of(input int c, input int m);
    if (m > c) return m - c;
    return (m + (MX - c)) & MX;
  endfunction

  // full one-shot run with the enable set: checks every tick
  task automatic run_to(input int m);
    int L, Le, v;
    bit ok;
    L = len_of(cur_c, m);
    Le = (L == 0) ? 1 : L;
    wr(8'h00, m);
    rd(8'h10, v);
    chk($sformatf("R2 start view c=%0d m=%0d", cur_c, m), v, (m - L) & MX);
    ok = 1'b1;
    tick_en = 1'b1;
    for (int k = 1; k <= Le; k++) begin
      @(negedge clk);
      rd(8'h10, v);
      if (k < Le) begin
        if (v != ((m - (L - k)) & MX) || irq_o !== 1'b0) ok = 1'b0;
      end else begin
        if (v != m || irq_o !== 1'b1) ok = 1'b0;
      end
    end
    chk($sformatf("R3 R5 tick trace c=%0d m=%0d", cur_c, m), ok, 1);
    @(negedge clk);
    tick_en = 1'b0;
    rd(8'h10, v);
    chk("R5 hold after expiry", v, m);
    wr(8'h14, 0);
    chk("R8 clear drops irq", irq_o, 0);
    cur_c = m;
  endtask

  // tick until the flag rises, then clear it
  task automatic drain(input int m);
    int s;
    tick_en = 1'b1;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      rd(8'h14, s);
      if (s == 1) break;
    end
    tick_en = 1'b0;
    wr(8'h14, 0);
    cur_c = m;
  endtask

  initial begin
    int v, v2, L;
    int vals[9] = '{0, 1, 5, 17, 31, 32, 50, 62, 63};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, v); chk("R1 reset counter", v, 0);
    rd(8'h14, v); chk("R1 reset status", v, 0);
    rd(8'h1C, v); chk("R1 reset enable", v, 0);
    chk("R1 reset irq", irq_o, 0);
    tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    rd(8'h10, v); chk("R1 stopped counter", v, 0);
    rd(8'h14, v); chk("R1 stopped status", v, 0);

    // R6 register layout
    wr(8'h1C, MX);
    rd(8'h1C, v); chk("R6 enable bit0 only", v, 1);
    wr(8'h00, 9);
    rd(8'h00, v); chk("R6 match write-only", v, 0);
    rd(8'h08, v); chk("R6 undefined reads zero", v, 0);
    drain(9);
    rd(8'h14, v); chk("R6 status cleared", v, 0);

    // sweep of stored counter and match pairs
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        run_to(vals[i]);
        run_to(vals[j]);
      end
    end

    // R4 freeze
    wr(8'h00, 40);
    L = len_of(cur_c, 40);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    rd(8'h10, v);
    chk("R4 three ticks", v, (40 - L + 3) & MX);
    repeat (5) @(negedge clk);
    rd(8'h10, v2);
    chk("R4 frozen view", v2, v);
    chk("R4 frozen irq", irq_o, 0);

    // R10 rewrite while running measures from stored counter
    wr(8'h00, 20);
    L = len_of(cur_c, 20);
    rd(8'h10, v);
    chk("R10 rewrite from stored", v, (20 - L) & MX);

    // R9 ignored writes
    wr(8'h04, 7); wr(8'h11, 7); wr(8'h1D, 0); wr(8'h15, 1); wr(8'h20, 3); wr(8'h01, 2);
    rd(8'h10, v2); chk("R9 counter unchanged", v2, v);
    rd(8'h1C, v2); chk("R9 enable unchanged", v2, 1);
    rd(8'h14, v2); chk("R9 status unchanged", v2, 0);
    drain(20);

    // R10 write collides with a tick
    tick_en = 1'b1;
    L = len_of(cur_c, 30);
    wr(8'h00, 30);
    rd(8'h10, v);
    chk("R10 tick dropped on load", v, (30 - L) & MX);
    @(negedge clk);
    rd(8'h10, v);
    chk("R10 next tick applies", v, (30 - L + 1) & MX);
    tick_en = 1'b0;
    drain(30);

    // R8 set wins over clear in the expiry cycle
    wr(8'h00, 34);
    L = len_of(cur_c, 34);
    tick_en = 1'b1;
    repeat (L - 1) @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h14; bus_wdata = '0;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 8'h10; tick_en = 1'b0;
    rd(8'h14, v); chk("R8 set wins status", v, 1);
    chk("R8 set wins irq", irq_o, 1);
    wr(8'h14, 0);
    cur_c = 34;

    // R7 late enable
    wr(8'h1C, 0);
    wr(8'h00, 38);
    drain_keep(38);
    rd(8'h14, v); chk("R7 flag set disabled", v, 1);
    chk("R7 irq gated off", irq_o, 0);
    wr(8'h1C, 1);
    chk("R7 late enable raises", irq_o, 1);
    wr(8'h14, 0);
    chk("R7 cleared", irq_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic drain_keep(input int m);
    int s;
    tick_en = 1'b1;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      rd(8'h14, s);
      if (s == 1) break;
    end
    tick_en = 1'b0;
    cur_c = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule